// File: doc/BRIEF.md
# Multi-Way Translation Buffer with ASID Rings

This block translates 32-bit virtual addresses for instruction fetch, load and store. It holds a set of ways, each a small direct-mapped array of page entries. By default there are ten ways: five with four entries, two with two entries and three with one entry. Pages are 4 KiB by default. Every way checks the entry picked by the low bits of the virtual page number. An entry hits when its page number matches and its ASID is nonzero. Its ASID must also appear in a 32-bit ring register that packs four 8-bit ASIDs, and the byte position of the match is the entry's protection ring.

A single hit is then checked in two steps. The first is privilege: the entry's ring must not be below the requested privilege index. The second is the access rights decoded from the entry's 4-bit attribute. If both pass, the block returns the physical address. Otherwise it returns a numbered exception cause. The lookup path is fully combinational.

Entries are written through one write port that takes a virtual address and a page-table entry word. The target way is either named by the caller or, for automatic refill, picked by a round-robin pointer over ways 0 to 3. The block also forms the address of the page-table entry that a walker would fetch for the current lookup address.

Top module: `tlb_asid_mmu`

## Requirements
- R1: After reset the ring register holds 0x04030201 and every entry has ASID 0, so every lookup misses.
- R2: An entry never hits if its ASID is 0 or equals none of the four bytes of the ring register. The ring register is replaced by `rasid_wdata` on the clock edge where `rasid_we` is high.
- R3: The ring of a hitting entry is the index i of the byte [8i+7:8i] of the ring register that equals its ASID. The lowest such index wins. The ring appears on `lk_ring`.
- R4: When two or more ways hit, the cause is 17 for a fetch (kind 2) and 25 for any other kind, and `lk_hit` stays low.
- R5: When no way hits, the cause is 16 for a fetch and 24 otherwise. `lk_fault` is high exactly when `lk_hit` is low, and the cause is 0 on a hit.
- R6: On a single hit whose ring is lower than `lk_priv`, the cause is 18 for a fetch and 26 otherwise.
- R7: Rights on `lk_rights` are [0] read, [1] write, [2] execute. An attribute below 12 grants read, adds execute when its bit 0 is set and adds write when its bit 1 is set. Attribute 13 grants read and write. Any other attribute grants nothing.
- R8: Access kinds are 0 load, 1 store, 2 fetch and 3 reserved. A kind-3 access is never granted and is handled like a store. A denied access gives cause 20 for a fetch, 28 for a load and 29 for a store or kind 3.
- R9: On a hit, `lk_paddr` is the entry's page number above the page-offset bits of `lk_vaddr`.
- R10: The write port stores the page number from `wr_vaddr`, and takes these fields from `wr_pte`: physical page number in [31:12], ring in [5:4] and attribute in [3:0]. The stored ASID is the ring register byte selected by that ring. The write takes effect at the next clock edge.
- R11: With `wr_auto` high, the write goes to way `auto_way`. `auto_way` is 1 after reset and advances 1, 2, 3, 0 after each automatic write. Otherwise the write goes to `wr_way`.
- R12: `pte_addr` equals (`pt_base` OR (`lk_vaddr` >> 10)) with bits [1:0] cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rasid_we | input | 1 | Load the ring register |
| rasid_wdata | input | 32 | New ring register value |
| wr_en | input | 1 | Write one entry |
| wr_auto | input | 1 | Use the round-robin way for this write |
| wr_way | input | 4 | Target way for a directed write |
| wr_vaddr | input | 32 | Virtual address of the written entry |
| wr_pte | input | 32 | Page-table entry word to store |
| auto_way | output | 4 | Way the next automatic write will use |
| pt_base | input | 32 | Page-table base address |
| pte_addr | output | 32 | Page-table entry address for `lk_vaddr` |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_kind | input | 2 | Access kind |
| lk_priv | input | 2 | Requested privilege index |
| lk_hit | output | 1 | Translation granted |
| lk_fault | output | 1 | Translation refused |
| lk_cause | output | 6 | Exception cause, 0 on a hit |
| lk_ring | output | 2 | Ring of the selected entry |
| lk_rights | output | 3 | Decoded rights of the selected entry |
| lk_paddr | output | 32 | Physical address, 0 when not hit |

## Verification
Some properties are checked on every cycle. Hit and fault are exclusive and complementary. A fault always carries a nonzero cause. A granted translation keeps the page offset, and its ring is at least the requested privilege. A granted load has read rights. The round-robin pointer advances by exactly one per automatic write and holds otherwise. Other behaviour can only be shown by the bench's scenarios, which reach it through specific table contents: the cause value chosen for each access kind, the rights decode of each attribute, ring remapping after the ring register is rewritten, multi-hit resolution after an automatic refill overwrites one of the colliding ways, and the loss of all entries on a second reset.

// File: rtl/tlb_asid_mmu_pkg.sv
package tlb_asid_mmu_pkg;

   typedef enum logic [1:0] {
      KIND_LOAD  = 2'd0,
      KIND_STORE = 2'd1,
      KIND_FETCH = 2'd2,
      KIND_RSVD  = 2'd3
   } acc_kind_e;

   localparam logic [5:0] CS_NONE        = 6'd0;
   localparam logic [5:0] CS_I_MISS      = 6'd16;
   localparam logic [5:0] CS_I_MULTI     = 6'd17;
   localparam logic [5:0] CS_I_PRIV      = 6'd18;
   localparam logic [5:0] CS_I_DENY      = 6'd20;
   localparam logic [5:0] CS_D_MISS      = 6'd24;
   localparam logic [5:0] CS_D_MULTI     = 6'd25;
   localparam logic [5:0] CS_D_PRIV      = 6'd26;
   localparam logic [5:0] CS_LOAD_DENY   = 6'd28;
   localparam logic [5:0] CS_STORE_DENY  = 6'd29;

   localparam logic [31:0] RASID_RESET   = 32'h0403_0201;

   // rights vector: [0] read, [1] write, [2] execute
   function automatic logic [2:0] attr_rights(input logic [3:0] attr);
      logic [2:0] r;
      r = 3'b000;
      if (attr < 4'd12) begin
         r[0] = 1'b1;
         r[2] = attr[0];
         r[1] = attr[1];
      end else if (attr == 4'd13) begin
         r = 3'b011;
      end
      return r;
   endfunction

   function automatic logic kind_granted(input logic [1:0] kind, input logic [2:0] rights);
      case (kind)
         KIND_LOAD:  return rights[0];
         KIND_STORE: return rights[1];
         KIND_FETCH: return rights[2];
         default:    return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/tlb_ring_find.sv
module tlb_ring_find #(
   parameter int ASID_W = 8,
   parameter int RINGS  = 4
) (
   input  logic [RINGS*ASID_W-1:0] ring_reg,
   input  logic [ASID_W-1:0]       asid,
   output logic                    found,
   output logic [$clog2(RINGS)-1:0] ring
);
   localparam int RW = $clog2(RINGS);

   always_comb begin
      found = 1'b0;
      ring  = '0;
      for (int i = RINGS - 1; i >= 0; i--) begin
         if (ring_reg[i*ASID_W +: ASID_W] == asid) begin
            found = 1'b1;
            ring  = RW'(i);
         end
      end
   end
endmodule

// File: rtl/tlb_way.sv
module tlb_way #(
   parameter int ENTRIES = 4,
   parameter int VPN_W   = 20,
   parameter int ASID_W  = 8,
   parameter int RINGS   = 4
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     we,
   input  logic [VPN_W-1:0]         wr_vpn,
   input  logic [VPN_W-1:0]         wr_ppn,
   input  logic [ASID_W-1:0]        wr_asid,
   input  logic [3:0]               wr_attr,
   input  logic [VPN_W-1:0]         lk_vpn,
   input  logic [RINGS*ASID_W-1:0]  ring_reg,
   output logic                     hit,
   output logic [$clog2(RINGS)-1:0] ring,
   output logic [VPN_W-1:0]         ppn,
   output logic [3:0]               attr
);
   localparam int IDXW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   initial begin
      assert (ENTRIES >= 1 && (ENTRIES & (ENTRIES - 1)) == 0)
         else $error("tlb_way: ENTRIES must be a power of two");
      assert (IDXW < VPN_W) else $error("tlb_way: too many entries");
   end

   logic [VPN_W-1:0]  vpn_q  [ENTRIES];
   logic [VPN_W-1:0]  ppn_q  [ENTRIES];
   logic [ASID_W-1:0] asid_q [ENTRIES];
   logic [3:0]        attr_q [ENTRIES];

   logic [IDXW-1:0] wr_idx, lk_idx;

   generate
      if (ENTRIES > 1) begin : g_idx
         assign wr_idx = wr_vpn[IDXW-1:0];
         assign lk_idx = lk_vpn[IDXW-1:0];
      end else begin : g_single
         assign wr_idx = '0;
         assign lk_idx = '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int e = 0; e < ENTRIES; e++) asid_q[e] <= '0;
      end else if (we) begin
         asid_q[wr_idx] <= wr_asid;
      end
   end

   always_ff @(posedge clk) begin
      if (we) begin
         vpn_q[wr_idx]  <= wr_vpn;
         ppn_q[wr_idx]  <= wr_ppn;
         attr_q[wr_idx] <= wr_attr;
      end
   end

   logic ring_ok;

   tlb_ring_find #(.ASID_W(ASID_W), .RINGS(RINGS)) u_ring (
      .ring_reg (ring_reg),
      .asid     (asid_q[lk_idx]),
      .found    (ring_ok),
      .ring     (ring)
   );

   assign hit  = (asid_q[lk_idx] != '0) && ring_ok && (vpn_q[lk_idx] == lk_vpn);
   assign ppn  = ppn_q[lk_idx];
   assign attr = attr_q[lk_idx];
endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve
   import tlb_asid_mmu_pkg::*;
#(
   parameter int NUM_WAYS  = 10,
   parameter int VPN_W     = 20,
   parameter int PAGE_BITS = 12,
   parameter int RW        = 2
) (
   input  logic [NUM_WAYS-1:0]            way_hit,
   input  logic [NUM_WAYS-1:0][RW-1:0]    way_ring,
   input  logic [NUM_WAYS-1:0][VPN_W-1:0] way_ppn,
   input  logic [NUM_WAYS-1:0][3:0]       way_attr,
   input  logic [PAGE_BITS-1:0]           offset,
   input  logic [1:0]                     kind,
   input  logic [RW-1:0]                  priv,
   output logic                           hit,
   output logic [5:0]                     cause,
   output logic [RW-1:0]                  ring,
   output logic [2:0]                     rights,
   output logic [VPN_W+PAGE_BITS-1:0]     paddr
);
   localparam int CW = $clog2(NUM_WAYS + 1);

   logic [CW-1:0]    nhits;
   logic [RW-1:0]    sel_ring;
   logic [VPN_W-1:0] sel_ppn;
   logic [3:0]       sel_attr;
   logic             instr;

   always_comb begin
      nhits    = '0;
      sel_ring = '0;
      sel_ppn  = '0;
      sel_attr = '0;
      for (int w = 0; w < NUM_WAYS; w++) begin
         if (way_hit[w]) begin
            nhits    = nhits + CW'(1);
            sel_ring = sel_ring | way_ring[w];
            sel_ppn  = sel_ppn  | way_ppn[w];
            sel_attr = sel_attr | way_attr[w];
         end
      end
   end

   assign instr = (kind == KIND_FETCH);

   always_comb begin
      hit    = 1'b0;
      cause  = CS_NONE;
      rights = 3'b000;
      ring   = sel_ring;
      paddr  = '0;
      if (nhits == '0) begin
         cause = instr ? CS_I_MISS : CS_D_MISS;
      end else if (nhits > CW'(1)) begin
         cause = instr ? CS_I_MULTI : CS_D_MULTI;
      end else begin
         rights = attr_rights(sel_attr);
         if (sel_ring < priv) begin
            cause = instr ? CS_I_PRIV : CS_D_PRIV;
         end else if (!kind_granted(kind, rights)) begin
            cause = instr ? CS_I_DENY :
                    (kind == KIND_LOAD) ? CS_LOAD_DENY : CS_STORE_DENY;
         end else begin
            hit   = 1'b1;
            paddr = {sel_ppn, offset};
         end
      end
   end
endmodule

// File: rtl/tlb_asid_mmu.sv
module tlb_asid_mmu
   import tlb_asid_mmu_pkg::*;
#(
   parameter int NUM_WAYS    = 10,
   parameter int BIG_WAYS    = 5,
   parameter int BIG_ENTRIES = 4,
   parameter int MID_WAYS    = 2,
   parameter int MID_ENTRIES = 2,
   parameter int SML_ENTRIES = 1,
   parameter int PAGE_BITS   = 12,
   parameter int RR_WAYS     = 4,
   parameter int WAYW        = $clog2(NUM_WAYS)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            rasid_we,
   input  logic [31:0]     rasid_wdata,
   input  logic            wr_en,
   input  logic            wr_auto,
   input  logic [WAYW-1:0] wr_way,
   input  logic [31:0]     wr_vaddr,
   input  logic [31:0]     wr_pte,
   output logic [WAYW-1:0] auto_way,
   input  logic [31:0]     pt_base,
   output logic [31:0]     pte_addr,
   input  logic [31:0]     lk_vaddr,
   input  logic [1:0]      lk_kind,
   input  logic [1:0]      lk_priv,
   output logic            lk_hit,
   output logic            lk_fault,
   output logic [5:0]      lk_cause,
   output logic [1:0]      lk_ring,
   output logic [2:0]      lk_rights,
   output logic [31:0]     lk_paddr
);
   localparam int VA_W   = 32;
   localparam int ASID_W = 8;
   localparam int RINGS  = 4;
   localparam int RW     = $clog2(RINGS);
   localparam int VPN_W  = VA_W - PAGE_BITS;
   localparam int RRW    = $clog2(RR_WAYS);

   initial begin
      assert (RINGS * ASID_W == 32) else $error("ring register must be 32 bits");
      assert (PAGE_BITS == 12) else $error("PTE layout assumes 4 KiB pages");
      assert (RR_WAYS <= NUM_WAYS && (RR_WAYS & (RR_WAYS - 1)) == 0)
         else $error("round-robin span must be a power of two within NUM_WAYS");
      assert (BIG_WAYS + MID_WAYS <= NUM_WAYS) else $error("way groups exceed NUM_WAYS");
   end

   // ring register
   logic [31:0] rasid_q;
   always_ff @(posedge clk) begin
      if (rst)           rasid_q <= RASID_RESET;
      else if (rasid_we) rasid_q <= rasid_wdata;
   end

   // round-robin pointer for automatic refill
   logic [RRW-1:0] rr_q;
   always_ff @(posedge clk) begin
      if (rst)                    rr_q <= '0;
      else if (wr_en && wr_auto)  rr_q <= rr_q + RRW'(1);
   end
   assign auto_way = WAYW'(RRW'(rr_q + RRW'(1)));

   // write field extraction
   logic [WAYW-1:0]   tgt_way;
   logic [RW-1:0]     wr_ring;
   logic [ASID_W-1:0] wr_asid;
   logic [5:0]        unused_pte_bits;
   assign tgt_way         = wr_auto ? auto_way : wr_way;
   assign wr_ring         = wr_pte[5:4];
   assign wr_asid         = rasid_q[wr_ring*ASID_W +: ASID_W];
   assign unused_pte_bits = wr_pte[11:6];

   // page-table entry address
   assign pte_addr = (pt_base | (lk_vaddr >> 10)) & ~32'h3;

   logic [NUM_WAYS-1:0]            way_hit;
   logic [NUM_WAYS-1:0][RW-1:0]    way_ring;
   logic [NUM_WAYS-1:0][VPN_W-1:0] way_ppn;
   logic [NUM_WAYS-1:0][3:0]       way_attr;

   generate
      for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
         localparam int ENT = (w < BIG_WAYS) ? BIG_ENTRIES :
                              (w < BIG_WAYS + MID_WAYS) ? MID_ENTRIES : SML_ENTRIES;
         tlb_way #(.ENTRIES(ENT), .VPN_W(VPN_W), .ASID_W(ASID_W), .RINGS(RINGS)) u_way (
            .clk      (clk),
            .rst      (rst),
            .we       (wr_en && (tgt_way == WAYW'(w))),
            .wr_vpn   (wr_vaddr[VA_W-1:PAGE_BITS]),
            .wr_ppn   (wr_pte[31:PAGE_BITS]),
            .wr_asid  (wr_asid),
            .wr_attr  (wr_pte[3:0]),
            .lk_vpn   (lk_vaddr[VA_W-1:PAGE_BITS]),
            .ring_reg (rasid_q),
            .hit      (way_hit[w]),
            .ring     (way_ring[w]),
            .ppn      (way_ppn[w]),
            .attr     (way_attr[w])
         );
      end
   endgenerate

   tlb_resolve #(.NUM_WAYS(NUM_WAYS), .VPN_W(VPN_W), .PAGE_BITS(PAGE_BITS), .RW(RW)) u_res (
      .way_hit  (way_hit),
      .way_ring (way_ring),
      .way_ppn  (way_ppn),
      .way_attr (way_attr),
      .offset   (lk_vaddr[PAGE_BITS-1:0]),
      .kind     (lk_kind),
      .priv     (lk_priv),
      .hit      (lk_hit),
      .cause    (lk_cause),
      .ring     (lk_ring),
      .rights   (lk_rights),
      .paddr    (lk_paddr)
   );

   assign lk_fault = !lk_hit;
endmodule

// File: rtl/tlb_asid_mmu_chk.sv
module tlb_asid_mmu_chk #(
   parameter int PAGE_BITS = 12,
   parameter int WAYW      = 4
) (
   input logic            clk,
   input logic            rst,
   input logic            wr_en,
   input logic            wr_auto,
   input logic [WAYW-1:0] auto_way,
   input logic [31:0]     lk_vaddr,
   input logic [1:0]      lk_kind,
   input logic [1:0]      lk_priv,
   input logic            lk_hit,
   input logic            lk_fault,
   input logic [5:0]      lk_cause,
   input logic [1:0]      lk_ring,
   input logic [2:0]      lk_rights,
   input logic [31:0]     lk_paddr
);
   a_r5_hit_xor_fault: assert property (@(posedge clk) disable iff (rst)
      lk_hit != lk_fault);

   a_r5_fault_has_cause: assert property (@(posedge clk) disable iff (rst)
      lk_fault |-> lk_cause != 6'd0);

   a_r6_ring_meets_priv: assert property (@(posedge clk) disable iff (rst)
      lk_hit |-> lk_ring >= lk_priv);

   a_r7_load_needs_read: assert property (@(posedge clk) disable iff (rst)
      (lk_hit && lk_kind == 2'd0) |-> lk_rights[0]);

   a_r9_offset_kept: assert property (@(posedge clk) disable iff (rst)
      lk_hit |-> lk_paddr[PAGE_BITS-1:0] == lk_vaddr[PAGE_BITS-1:0]);

   a_r11_rr_advance: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_auto) |=> auto_way[1:0] == $past(auto_way[1:0]) + 2'd1);

   a_r11_rr_hold: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_auto) |=> $stable(auto_way));
endmodule

bind tlb_asid_mmu tlb_asid_mmu_chk #(.PAGE_BITS(PAGE_BITS), .WAYW(WAYW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .wr_en     (wr_en),
   .wr_auto   (wr_auto),
   .auto_way  (auto_way),
   .lk_vaddr  (lk_vaddr),
   .lk_kind   (lk_kind),
   .lk_priv   (lk_priv),
   .lk_hit    (lk_hit),
   .lk_fault  (lk_fault),
   .lk_cause  (lk_cause),
   .lk_ring   (lk_ring),
   .lk_rights (lk_rights),
   .lk_paddr  (lk_paddr)
);

// File: tb/test_tlb_asid_mmu.sv
module test_tlb_asid_mmu;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        rasid_we = 1'b0;
   logic [31:0] rasid_wdata = '0;
   logic        wr_en = 1'b0;
   logic        wr_auto = 1'b0;
   logic [3:0]  wr_way = '0;
   logic [31:0] wr_vaddr = '0;
   logic [31:0] wr_pte = '0;
   logic [3:0]  auto_way;
   logic [31:0] pt_base = '0;
   logic [31:0] pte_addr;
   logic [31:0] lk_vaddr = '0;
   logic [1:0]  lk_kind = '0;
   logic [1:0]  lk_priv = '0;
   logic        lk_hit, lk_fault;
   logic [5:0]  lk_cause;
   logic [1:0]  lk_ring;
   logic [2:0]  lk_rights;
   logic [31:0] lk_paddr;

   int n_checks = 0;
   int n_errors = 0;

   always #4 clk = ~clk;

   tlb_asid_mmu i_tlb_asid_mmu (
      .clk(clk), .rst(rst), .rasid_we(rasid_we), .rasid_wdata(rasid_wdata),
      .wr_en(wr_en), .wr_auto(wr_auto), .wr_way(wr_way), .wr_vaddr(wr_vaddr),
      .wr_pte(wr_pte), .auto_way(auto_way), .pt_base(pt_base), .pte_addr(pte_addr),
      .lk_vaddr(lk_vaddr), .lk_kind(lk_kind), .lk_priv(lk_priv), .lk_hit(lk_hit),
      .lk_fault(lk_fault), .lk_cause(lk_cause), .lk_ring(lk_ring),
      .lk_rights(lk_rights), .lk_paddr(lk_paddr)
   );

   typedef struct packed {
      logic [31:0] va;
      logic [1:0]  kind;
      logic [1:0]  priv;
      logic        hit;
      logic [5:0]  cause;
      logic [31:0] pa;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{32'h0000_1234, 2'd0, 2'd0, 1'b1, 6'd0,  32'hABCD_E234, 4'd9},  // R9 load hit
      '{32'h0000_1FFC, 2'd2, 2'd1, 1'b1, 6'd0,  32'hABCD_EFFC, 4'd7},  // R7 exec from attr 3
      '{32'h0000_1000, 2'd1, 2'd2, 1'b0, 6'd26, 32'h0,         4'd6},  // R6 data priv
      '{32'h0000_1000, 2'd2, 2'd3, 1'b0, 6'd18, 32'h0,         4'd6},  // R6 fetch priv
      '{32'h2000_0010, 2'd0, 2'd0, 1'b1, 6'd0,  32'h1234_5010, 4'd9},  // R9 one-entry way
      '{32'h2000_0010, 2'd1, 2'd0, 1'b1, 6'd0,  32'h1234_5010, 4'd7},  // R7 attr 13 write
      '{32'h2000_0010, 2'd2, 2'd0, 1'b0, 6'd20, 32'h0,         4'd8},  // R8 attr 13 no exec
      '{32'h0000_3000, 2'd0, 2'd0, 1'b0, 6'd25, 32'h0,         4'd4},  // R4 data multi
      '{32'h0000_3008, 2'd2, 2'd0, 1'b0, 6'd17, 32'h0,         4'd4},  // R4 fetch multi
      '{32'h0000_5000, 2'd0, 2'd0, 1'b0, 6'd28, 32'h0,         4'd8},  // R8 attr 12 load
      '{32'h0000_5000, 2'd1, 2'd0, 1'b0, 6'd29, 32'h0,         4'd8},  // R8 attr 12 store
      '{32'h0000_6ABC, 2'd0, 2'd3, 1'b1, 6'd0,  32'h0006_6ABC, 4'd3},  // R3 ring 3 entry
      '{32'h0000_6000, 2'd3, 2'd0, 1'b0, 6'd29, 32'h0,         4'd8},  // R8 reserved kind
      '{32'h0000_9000, 2'd2, 2'd0, 1'b0, 6'd16, 32'h0,         4'd5}   // R5 fetch miss
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic lookup(input logic [31:0] va, input logic [1:0] kind, input logic [1:0] priv);
      @(negedge clk);
      lk_vaddr = va; lk_kind = kind; lk_priv = priv;
      #2;
   endtask

   task automatic write_entry(input logic auto_sel, input logic [3:0] way,
                              input logic [31:0] va, input logic [31:0] pte);
      @(negedge clk);
      wr_en = 1'b1; wr_auto = auto_sel; wr_way = way; wr_vaddr = va; wr_pte = pte;
      @(negedge clk);
      wr_en = 1'b0; wr_auto = 1'b0;
   endtask

   task automatic set_rasid(input logic [31:0] v);
      @(negedge clk);
      rasid_we = 1'b1; rasid_wdata = v;
      @(negedge clk);
      rasid_we = 1'b0;
   endtask

   initial begin
      #1_000_000;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1: empty after reset
      lookup(32'h0000_1234, 2'd0, 2'd0);
      chk("R1 reset miss cause", 32'(lk_cause), 32'd24);
      chk("R1 reset no hit", 32'(lk_hit), 32'd0);
      chk("R11 auto_way after reset", 32'(auto_way), 32'd1);

      // fill table (R10): pte = ppn[31:12], ring[5:4], attr[3:0]
      write_entry(1'b0, 4'd0, 32'h0000_1000, 32'hABCD_E013);
      write_entry(1'b0, 4'd7, 32'h2000_0000, 32'h1234_500D);
      write_entry(1'b0, 4'd1, 32'h0000_3000, 32'h0003_3002);
      write_entry(1'b0, 4'd2, 32'h0000_3000, 32'h0003_3002);
      write_entry(1'b0, 4'd3, 32'h0000_5000, 32'h0005_502C);
      write_entry(1'b0, 4'd4, 32'h0000_6000, 32'h0006_6030);

      // R10: write lands at the next edge
      lookup(32'h0000_1234, 2'd0, 2'd0);
      chk("R10 written entry ring", 32'(lk_ring), 32'd1);

      for (int i = 0; i < NV; i++) begin
         lookup(VECS[i].va, VECS[i].kind, VECS[i].priv);
         chk($sformatf("R%0d vec%0d hit", VECS[i].req, i), 32'(lk_hit), 32'(VECS[i].hit));
         chk($sformatf("R%0d vec%0d cause", VECS[i].req, i), 32'(lk_cause), 32'(VECS[i].cause));
         chk($sformatf("R%0d vec%0d paddr", VECS[i].req, i), lk_paddr, VECS[i].pa);
      end

      // R7 rights vectors
      lookup(32'h0000_1000, 2'd0, 2'd0);
      chk("R7 rights attr3", 32'(lk_rights), 32'b111);
      lookup(32'h0000_6000, 2'd0, 2'd0);
      chk("R7 rights attr0", 32'(lk_rights), 32'b001);
      lookup(32'h0000_5000, 2'd0, 2'd0);
      chk("R7 rights attr12", 32'(lk_rights), 32'b000);

      // R2: asid 0x02 dropped from ring register
      set_rasid(32'h0403_0901);
      lookup(32'h0000_1234, 2'd0, 2'd0);
      chk("R2 unlisted asid misses", 32'(lk_cause), 32'd24);
      // R3: asid 0x02 moved to ring 3
      set_rasid(32'h0203_0401);
      lookup(32'h0000_1234, 2'd0, 2'd3);
      chk("R3 remapped ring", 32'(lk_ring), 32'd3);
      chk("R3 remapped hit", 32'(lk_hit), 32'd1);
      set_rasid(32'h0403_0201);

      // R12 pte address
      pt_base = 32'h8000_0000;
      lookup(32'h1234_5678, 2'd0, 2'd0);
      chk("R12 pte address", pte_addr, 32'h8004_8D14);

      // R11 automatic refill: first goes to way 1, index of 0x7000 is 3
      write_entry(1'b1, 4'd9, 32'h0000_7000, 32'h0007_7013);
      chk("R11 auto_way step", 32'(auto_way), 32'd2);
      lookup(32'h0000_7004, 2'd0, 2'd1);
      chk("R11 auto entry hit", lk_paddr, 32'h0007_7004);
      lookup(32'h0000_3000, 2'd0, 2'd0);
      chk("R4 multi resolved by refill", lk_paddr, 32'h0003_3000);
      write_entry(1'b1, 4'd9, 32'h0000_8000, 32'h0008_8013);
      chk("R11 auto_way step", 32'(auto_way), 32'd3);
      write_entry(1'b1, 4'd9, 32'h0000_8000, 32'h0008_8013);
      chk("R11 auto_way wrap", 32'(auto_way), 32'd0);
      write_entry(1'b0, 4'd5, 32'h0000_8000, 32'h0008_8013);
      chk("R11 directed write holds pointer", 32'(auto_way), 32'd0);

      // R1: second reset clears entries
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      lookup(32'h0000_1234, 2'd2, 2'd0);
      chk("R1 entries cleared", 32'(lk_cause), 32'd16);
      chk("R1 pointer cleared", 32'(auto_way), 32'd1);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule